// File: doc/BRIEF.md
# Enclave Thread-Entry Precondition Validator

This block decides whether a request to enter a protected enclave thread may go ahead. The requester presents a thread control page address together with a snapshot of that page's contents. The snapshot covers the flags word, the current and total save-frame counts and the thread's activity state. The requester also presents the page's metadata entry, the enclave's attributes and the relevant processor mode and control bits, and pulses `start`. One cycle later the block pulses `done` and reports a verdict. The verdict is pass, a general-protection fault, or a page fault that carries the offending address.

The block evaluates thirteen conditions in a fixed priority order. When several conditions fail in the same request, only the first failing one in that order determines the verdict. The verdict and the fault address stay on the outputs until the next request completes. Memory access and the state swap that follows a successful entry lie outside this block.

Top module: `thread_entry_check`

## Requirements
- R1: `done` is a single-cycle pulse in the cycle after each `start` and is low otherwise. After reset, `done`, `fault_class` and `fault_addr` are all zero, and the verdict holds until the next request completes.
- R2: `fault_class` uses 2'b00 for pass, 2'b01 for general-protection and 2'b10 for page fault, and never takes 2'b11. `fault_addr` equals the request address on a page fault and is zero otherwise.
- R3: A request address whose low 12 bits are not all zero gives a general-protection fault, and this check comes ahead of every metadata check.
- R4: A page fault is reported when the metadata entry is not valid, is blocked, records an owner address different from the request address, has a page type other than thread-control (code 8'h01), or is pending or modified.
- R5: Any set bit of the 64-bit flags word other than bit 0 (debug opt-in) and bit 1 (exit-notify) gives a general-protection fault.
- R6: A general-protection fault is reported when the enclave is not initialized, or when the processor's 64-bit mode bit differs from the enclave's 64-bit mode attribute.
- R7: A general-protection fault is reported when the processor's legacy floating-point save enable is off.
- R8: When the extended-save enable is off, the enclave feature mask must equal 3. When it is on, the mask must have no bit outside the active feature register. Otherwise a general-protection fault is reported.
- R9: When flags bit 0 is zero and flags bit 1 differs from the enclave's exit-notify attribute, a general-protection fault is reported. When bit 0 is one, a mismatch is accepted.
- R10: A current save-frame index greater than or equal to the number of save frames gives a general-protection fault. An index one below the count is accepted.
- R11: A thread whose state is already active gives a general-protection fault.
- R12: The priority order is: alignment; metadata valid; blocked; owner or type; pending or modified; flags reserved bits; initialized; mode; floating-point save enable; feature mask; exit-notify; save-frame index; thread state. Only the first failing check sets the verdict.
- R13: A request that meets every condition is reported as pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; all other inputs are sampled with it |
| req_addr | input | AW (48) | Thread control page address |
| tcp_flags | input | FW (64) | Flags word of the control page |
| cur_frame | input | IW (32) | Current save-frame index |
| num_frames | input | IW (32) | Number of save frames |
| thr_active | input | 1 | Thread state is active |
| meta_valid | input | 1 | Metadata entry valid |
| meta_blocked | input | 1 | Metadata entry blocked |
| meta_pending | input | 1 | Metadata entry pending |
| meta_modified | input | 1 | Metadata entry modified |
| meta_type | input | TW (8) | Page type recorded in metadata |
| meta_owner | input | AW (48) | Owner address recorded in metadata |
| encl_init | input | 1 | Enclave has been initialized |
| encl_mode64 | input | 1 | Enclave 64-bit mode attribute |
| encl_fmask | input | XW (64) | Enclave feature mask |
| encl_notify | input | 1 | Enclave exit-notify attribute |
| cpu_mode64 | input | 1 | Processor is in 64-bit mode |
| cpu_xsave_en | input | 1 | OS extended-save enable |
| cpu_fxsave_en | input | 1 | OS legacy floating-point save enable |
| act_fmask | input | XW (64) | Active feature register |
| done | output | 1 | Verdict-valid pulse |
| fault_class | output | 2 | Verdict class |
| fault_addr | output | AW (48) | Faulting address for a page fault |

## Verification
Several failing conditions can coincide in one request, and the verdict must then name only the highest-ranked one. The bench provokes this by injecting pairs of faults whose classes differ. A misaligned address is paired with an invalid metadata entry, and metadata faults are paired with later general-protection conditions such as reserved flags, an active thread or an exhausted frame index. Each pair is judged on the class and on whether the request address appears as the fault address. A behavioural priority model, compared on every clock, checks the verdict for every request.

// File: rtl/tec_pkg.sv
package tec_pkg;

  typedef enum logic [1:0] {
    FC_PASS = 2'b00,
    FC_GP   = 2'b01,
    FC_PF   = 2'b10
  } fclass_e;

  // Check slots, lowest index has highest priority.
  localparam int CK_ALIGN   = 0;
  localparam int CK_MVALID  = 1;
  localparam int CK_MBLOCK  = 2;
  localparam int CK_MOWNER  = 3;
  localparam int CK_MPEND   = 4;
  localparam int CK_FLAGS   = 5;
  localparam int CK_INIT    = 6;
  localparam int CK_MODE    = 7;
  localparam int CK_FXSAVE  = 8;
  localparam int CK_FMASK   = 9;
  localparam int CK_NOTIFY  = 10;
  localparam int CK_FRAME   = 11;
  localparam int CK_ACTIVE  = 12;
  localparam int N_CHECKS   = 13;

  localparam int N_PAGE_CK  = CK_FLAGS;
  localparam int N_ATTR_CK  = N_CHECKS - N_PAGE_CK;

  // Slots that raise a page fault; every other slot raises a GP fault.
  localparam logic [N_CHECKS-1:0] PF_SLOTS =
    N_CHECKS'((1 << CK_MVALID) | (1 << CK_MBLOCK) | (1 << CK_MOWNER) | (1 << CK_MPEND));

endpackage

// File: rtl/tec_page_chk.sv
module tec_page_chk #(
  parameter int AW        = 48,
  parameter int TW        = 8,
  parameter int PAGE_BITS = 12,
  parameter logic [TW-1:0] TCP_TYPE = 8'h01
) (
  input  logic [AW-1:0] req_addr,
  input  logic          meta_valid,
  input  logic          meta_blocked,
  input  logic          meta_pending,
  input  logic          meta_modified,
  input  logic [TW-1:0] meta_type,
  input  logic [AW-1:0] meta_owner,
  output logic [tec_pkg::N_PAGE_CK-1:0] fail
);
  import tec_pkg::*;

  function automatic logic misaligned(input logic [AW-1:0] a);
    return a[PAGE_BITS-1:0] != '0;
  endfunction

  function automatic logic bad_identity(input logic [AW-1:0] a,
                                        input logic [AW-1:0] own,
                                        input logic [TW-1:0] ty);
    return (own != a) || (ty != TCP_TYPE);
  endfunction

  always_comb begin
    fail            = '0;
    fail[CK_ALIGN]  = misaligned(req_addr);
    fail[CK_MVALID] = !meta_valid;
    fail[CK_MBLOCK] = meta_blocked;
    fail[CK_MOWNER] = bad_identity(req_addr, meta_owner, meta_type);
    fail[CK_MPEND]  = meta_pending || meta_modified;
  end

endmodule

// File: rtl/tec_attr_chk.sv
module tec_attr_chk #(
  parameter int FW = 64,
  parameter int IW = 32,
  parameter int XW = 64,
  parameter int OPTIN_BIT  = 0,
  parameter int NOTIFY_BIT = 1,
  parameter logic [XW-1:0] LEGACY_FMASK = 3
) (
  input  logic [FW-1:0] tcp_flags,
  input  logic [IW-1:0] cur_frame,
  input  logic [IW-1:0] num_frames,
  input  logic          thr_active,
  input  logic          encl_init,
  input  logic          encl_mode64,
  input  logic [XW-1:0] encl_fmask,
  input  logic          encl_notify,
  input  logic          cpu_mode64,
  input  logic          cpu_xsave_en,
  input  logic          cpu_fxsave_en,
  input  logic [XW-1:0] act_fmask,
  output logic [tec_pkg::N_ATTR_CK-1:0] fail
);
  import tec_pkg::*;

  localparam int LOW_KEEP = ((OPTIN_BIT > NOTIFY_BIT) ? OPTIN_BIT : NOTIFY_BIT) + 1;
  localparam logic [FW-1:0] RSVD_MASK = ~((FW'(1) << LOW_KEEP) - FW'(1));

  function automatic logic fmask_bad(input logic xs_en,
                                     input logic [XW-1:0] want,
                                     input logic [XW-1:0] have);
    if (xs_en) return (want & ~have) != '0;
    return want != LEGACY_FMASK;
  endfunction

  function automatic logic notify_bad(input logic [FW-1:0] fl, input logic attr);
    return !fl[OPTIN_BIT] && (fl[NOTIFY_BIT] != attr);
  endfunction

  function automatic logic frame_bad(input logic [IW-1:0] cur, input logic [IW-1:0] tot);
    return cur >= tot;
  endfunction

  always_comb begin
    fail                       = '0;
    fail[CK_FLAGS  - N_PAGE_CK] = (tcp_flags & RSVD_MASK) != '0;
    fail[CK_INIT   - N_PAGE_CK] = !encl_init;
    fail[CK_MODE   - N_PAGE_CK] = cpu_mode64 != encl_mode64;
    fail[CK_FXSAVE - N_PAGE_CK] = !cpu_fxsave_en;
    fail[CK_FMASK  - N_PAGE_CK] = fmask_bad(cpu_xsave_en, encl_fmask, act_fmask);
    fail[CK_NOTIFY - N_PAGE_CK] = notify_bad(tcp_flags, encl_notify);
    fail[CK_FRAME  - N_PAGE_CK] = frame_bad(cur_frame, num_frames);
    fail[CK_ACTIVE - N_PAGE_CK] = thr_active;
  end

endmodule

// File: rtl/tec_prio_sel.sv
module tec_prio_sel #(
  parameter int N = 13,
  parameter logic [N-1:0] PF_MASK = '0
) (
  input  logic [N-1:0] fail,
  output logic [N-1:0] win,
  output logic [1:0]   cls
);
  import tec_pkg::*;

  logic [N-1:0] seen_before;

  assign seen_before[0] = 1'b0;
  assign win[0]         = fail[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign seen_before[i] = seen_before[i-1] | fail[i-1];
    assign win[i]         = fail[i] & ~seen_before[i];
  end

  always_comb begin
    if (fail == '0)                 cls = FC_PASS;
    else if ((win & PF_MASK) != '0) cls = FC_PF;
    else                            cls = FC_GP;
  end

endmodule

// File: rtl/thread_entry_check.sv
module thread_entry_check #(
  parameter int AW        = 48,
  parameter int FW        = 64,
  parameter int IW        = 32,
  parameter int XW        = 64,
  parameter int TW        = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic [FW-1:0] tcp_flags,
  input  logic [IW-1:0] cur_frame,
  input  logic [IW-1:0] num_frames,
  input  logic          thr_active,
  input  logic          meta_valid,
  input  logic          meta_blocked,
  input  logic          meta_pending,
  input  logic          meta_modified,
  input  logic [TW-1:0] meta_type,
  input  logic [AW-1:0] meta_owner,
  input  logic          encl_init,
  input  logic          encl_mode64,
  input  logic [XW-1:0] encl_fmask,
  input  logic          encl_notify,
  input  logic          cpu_mode64,
  input  logic          cpu_xsave_en,
  input  logic          cpu_fxsave_en,
  input  logic [XW-1:0] act_fmask,
  output logic          done,
  output logic [1:0]    fault_class,
  output logic [AW-1:0] fault_addr
);
  import tec_pkg::*;

  // Named internal events, observed by the bound checker.
  logic [N_PAGE_CK-1:0] page_fail;
  logic [N_ATTR_CK-1:0] attr_fail;
  logic [N_CHECKS-1:0]  fail_vec;
  logic [N_CHECKS-1:0]  win_vec;
  logic [1:0]           next_class;
  logic [AW-1:0]        next_addr;

  tec_page_chk #(
    .AW(AW), .TW(TW), .PAGE_BITS(PAGE_BITS), .TCP_TYPE(TW'(1))
  ) u_page (
    .req_addr      (req_addr),
    .meta_valid    (meta_valid),
    .meta_blocked  (meta_blocked),
    .meta_pending  (meta_pending),
    .meta_modified (meta_modified),
    .meta_type     (meta_type),
    .meta_owner    (meta_owner),
    .fail          (page_fail)
  );

  tec_attr_chk #(
    .FW(FW), .IW(IW), .XW(XW)
  ) u_attr (
    .tcp_flags     (tcp_flags),
    .cur_frame     (cur_frame),
    .num_frames    (num_frames),
    .thr_active    (thr_active),
    .encl_init     (encl_init),
    .encl_mode64   (encl_mode64),
    .encl_fmask    (encl_fmask),
    .encl_notify   (encl_notify),
    .cpu_mode64    (cpu_mode64),
    .cpu_xsave_en  (cpu_xsave_en),
    .cpu_fxsave_en (cpu_fxsave_en),
    .act_fmask     (act_fmask),
    .fail          (attr_fail)
  );

  assign fail_vec = {attr_fail, page_fail};

  tec_prio_sel #(
    .N(N_CHECKS), .PF_MASK(PF_SLOTS)
  ) u_prio (
    .fail (fail_vec),
    .win  (win_vec),
    .cls  (next_class)
  );

  assign next_addr = (next_class == FC_PF) ? req_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fault_class <= FC_PASS;
      fault_addr  <= '0;
    end else begin
      done <= start;
      if (start) begin
        fault_class <= next_class;
        fault_addr  <= next_addr;
      end
    end
  end

endmodule

// File: rtl/tec_chk.sv
module tec_chk #(
  parameter int AW        = 48,
  parameter int IW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int N         = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] req_addr,
  input logic [IW-1:0] cur_frame,
  input logic [IW-1:0] num_frames,
  input logic          thr_active,
  input logic          meta_valid,
  input logic          done,
  input logic [1:0]    fault_class,
  input logic [AW-1:0] fault_addr,
  input logic [N-1:0]  fail_vec,
  input logic [N-1:0]  win_vec
);

  assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_class_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_class != 2'b11);

  assert_addr_only_on_pf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_class != 2'b10) |-> (fault_addr == '0));

  assert_align_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && req_addr[PAGE_BITS-1:0] != '0) |=> (fault_class == 2'b01));

  assert_invalid_meta_pf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && req_addr[PAGE_BITS-1:0] == '0 && !meta_valid)
      |=> (fault_class == 2'b10 && fault_addr == $past(req_addr)));

  assert_frame_exhausted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cur_frame >= num_frames) |=> (fault_class != 2'b00));

  assert_active_thread_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && thr_active) |=> (fault_class != 2'b00));

  assert_single_winner_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  assert_winner_failed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_vec != '0) |-> ($countones(win_vec & fail_vec) == 1));

endmodule

bind thread_entry_check tec_chk #(
  .AW(AW), .IW(IW), .PAGE_BITS(PAGE_BITS), .N(tec_pkg::N_CHECKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .req_addr    (req_addr),
  .cur_frame   (cur_frame),
  .num_frames  (num_frames),
  .thr_active  (thr_active),
  .meta_valid  (meta_valid),
  .done        (done),
  .fault_class (fault_class),
  .fault_addr  (fault_addr),
  .fail_vec    (fail_vec),
  .win_vec     (win_vec)
);

// File: tb/thread_entry_check_test.sv
module thread_entry_check_test;

  typedef struct {
    logic [47:0] addr;
    logic [63:0] flags;
    logic [31:0] cur;
    logic [31:0] num;
    logic        act;
    logic        mv, mb, mp, mm;
    logic [7:0]  mt;
    logic [47:0] mo;
    logic        ei, em, en;
    logic [63:0] efm;
    logic        cm, cx, cf;
    logic [63:0] afm;
  } req_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  req_t        rq;
  logic        done;
  logic [1:0]  fault_class;
  logic [47:0] fault_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic        exp_done = 1'b0;
  logic [1:0]  exp_cls  = 2'b00;
  logic [47:0] exp_addr = '0;

  always #2.5 clk = ~clk;

  thread_entry_check uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_addr(rq.addr), .tcp_flags(rq.flags),
    .cur_frame(rq.cur), .num_frames(rq.num), .thr_active(rq.act),
    .meta_valid(rq.mv), .meta_blocked(rq.mb), .meta_pending(rq.mp),
    .meta_modified(rq.mm), .meta_type(rq.mt), .meta_owner(rq.mo),
    .encl_init(rq.ei), .encl_mode64(rq.em), .encl_fmask(rq.efm),
    .encl_notify(rq.en), .cpu_mode64(rq.cm), .cpu_xsave_en(rq.cx),
    .cpu_fxsave_en(rq.cf), .act_fmask(rq.afm),
    .done(done), .fault_class(fault_class), .fault_addr(fault_addr)
  );

  // Behavioural verdict, written as a first-match decision list.
  function automatic logic [49:0] verdict(input req_t r);
    logic [1:0] c;
    logic [47:0] a;
    a = '0;
    if (r.addr % 4096 != 0) c = 2'd1;
    else if (!r.mv || r.mb || r.mo != r.addr || r.mt != 8'h01 || r.mp || r.mm) begin
      c = 2'd2;
      a = r.addr;
    end
    else if (r.flags > 64'd3) c = 2'd1;
    else if (!r.ei) c = 2'd1;
    else if (r.cm != r.em) c = 2'd1;
    else if (!r.cf) c = 2'd1;
    else if (!r.cx && r.efm != 64'd3) c = 2'd1;
    else if (r.cx && ((r.efm | r.afm) != r.afm)) c = 2'd1;
    else if (r.flags[0] == 1'b0 && r.flags[1] != r.en) c = 2'd1;
    else if (!(r.cur < r.num)) c = 2'd1;
    else if (r.act) c = 2'd1;
    else c = 2'd0;
    return {c, a};
  endfunction

  function automatic req_t good_req();
    req_t r;
    r.addr = 48'h0000_1234_5000; r.flags = 64'd0;
    r.cur = 32'd0; r.num = 32'd2; r.act = 1'b0;
    r.mv = 1'b1; r.mb = 1'b0; r.mp = 1'b0; r.mm = 1'b0;
    r.mt = 8'h01; r.mo = r.addr;
    r.ei = 1'b1; r.em = 1'b1; r.en = 1'b0; r.efm = 64'd3;
    r.cm = 1'b1; r.cx = 1'b1; r.cf = 1'b1; r.afm = 64'd7;
    return r;
  endfunction

  // Cycle model of the outputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_done <= 1'b0; exp_cls <= 2'b00; exp_addr <= '0;
    end else begin
      exp_done <= start;
      if (start) {exp_cls, exp_addr} <= verdict(rq);
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R1, R2 and the priority order R12).
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", "model done", 64'(done), 64'(exp_done));
      check("R12", "model class", 64'(fault_class), 64'(exp_cls));
      check("R2", "model addr", 64'(fault_addr), 64'(exp_addr));
    end
  end

  // Issue one request and check the verdict against a hand-derived expectation.
  task automatic run(input string tag, input req_t r, input logic [1:0] cls, input logic use_addr);
    rq = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tag, "done", 64'(done), 64'd1);
    check(tag, "class", 64'(fault_class), 64'(cls));
    check(tag, "addr", 64'(fault_addr), use_addr ? 64'(r.addr) : 64'd0);
    @(negedge clk);
    check(tag, "done drop", 64'(done), 64'd0);
    check(tag, "class hold", 64'(fault_class), 64'(cls));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req_t r;
    rq = good_req();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset done", 64'(done), 64'd0);
    check("R1", "reset class", 64'(fault_class), 64'd0);
    check("R1", "reset addr", 64'(fault_addr), 64'd0);

    run("R13 all good", good_req(), 2'b00, 1'b0);

    r = good_req(); r.addr = 48'h0000_1234_5008; r.mo = r.addr;
    run("R3 misaligned", r, 2'b01, 1'b0);

    r = good_req(); r.mv = 1'b0;            run("R4 invalid", r, 2'b10, 1'b1);
    r = good_req(); r.mb = 1'b1;            run("R4 blocked", r, 2'b10, 1'b1);
    r = good_req(); r.mo = 48'h0000_1234_6000; run("R4 owner", r, 2'b10, 1'b1);
    r = good_req(); r.mt = 8'h03;           run("R4 type", r, 2'b10, 1'b1);
    r = good_req(); r.mp = 1'b1;            run("R4 pending", r, 2'b10, 1'b1);
    r = good_req(); r.mm = 1'b1;            run("R4 modified", r, 2'b10, 1'b1);

    r = good_req(); r.flags = 64'h4;        run("R5 bit2", r, 2'b01, 1'b0);
    r = good_req(); r.flags = 64'h8000_0000_0000_0000; run("R5 bit63", r, 2'b01, 1'b0);

    r = good_req(); r.ei = 1'b0;            run("R6 uninit", r, 2'b01, 1'b0);
    r = good_req(); r.cm = 1'b0;            run("R6 mode", r, 2'b01, 1'b0);
    r = good_req(); r.cf = 1'b0;            run("R7 fxsave off", r, 2'b01, 1'b0);

    r = good_req(); r.cx = 1'b0;            run("R8 legacy mask 3", r, 2'b00, 1'b0);
    r = good_req(); r.cx = 1'b0; r.efm = 64'd7; r.afm = 64'hFF; run("R8 legacy mask 7", r, 2'b01, 1'b0);
    r = good_req(); r.efm = 64'd7;          run("R8 subset", r, 2'b00, 1'b0);
    r = good_req(); r.efm = 64'hB;          run("R8 not subset", r, 2'b01, 1'b0);

    r = good_req(); r.flags = 64'h2;        run("R9 notify mismatch", r, 2'b01, 1'b0);
    r = good_req(); r.flags = 64'h3;        run("R9 opt-in accepts", r, 2'b00, 1'b0);
    r = good_req(); r.flags = 64'h2; r.en = 1'b1; run("R9 notify match", r, 2'b00, 1'b0);

    r = good_req(); r.cur = 32'd1;          run("R10 last frame", r, 2'b00, 1'b0);
    r = good_req(); r.cur = 32'd2;          run("R10 frame equal", r, 2'b01, 1'b0);
    r = good_req(); r.act = 1'b1;           run("R11 active", r, 2'b01, 1'b0);

    // Fault pairs across classes.
    r = good_req(); r.addr = 48'h0000_1234_5010; r.mo = r.addr; r.mv = 1'b0;
    run("R12 align over invalid", r, 2'b01, 1'b0);
    r = good_req(); r.mv = 1'b0; r.flags = 64'h10;
    run("R12 invalid over flags", r, 2'b10, 1'b1);
    r = good_req(); r.mb = 1'b1; r.act = 1'b1;
    run("R12 blocked over active", r, 2'b10, 1'b1);
    r = good_req(); r.mm = 1'b1; r.cur = 32'd5;
    run("R12 modified over frame", r, 2'b10, 1'b1);
    r = good_req(); r.mt = 8'h00; r.ei = 1'b0;
    run("R12 type over uninit", r, 2'b10, 1'b1);

    // Back-to-back requests: each verdict one cycle after its start.
    rq = good_req(); rq.mp = 1'b1; start = 1'b1;
    @(negedge clk);
    check("R1 b2b first", "class", 64'(fault_class), 64'd2);
    rq = good_req();
    @(negedge clk);
    start = 1'b0;
    check("R1 b2b second", "class", 64'(fault_class), 64'd0);
    check("R2 b2b second", "addr", 64'(fault_addr), 64'd0);
    @(negedge clk);
    check("R1 b2b idle", "done", 64'(done), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule